// File: doc/BRIEF.md
# Operand Mode Decoder with Constant Generation

This block turns the addressing fields of a 16-bit two-address instruction word into a classified description of each operand. It takes the source register number, the two-bit source mode, the destination register number, the one-bit destination mode, a byte/word flag and a flag that marks single-operand instructions. For each side it reports what kind of operand the fields encode. It also reports whether that operand takes an extension word, the value of any generated constant, the post-increment step, the instruction length in words and the execution cycle count.

Two registers carry special meanings. Register 3 produces constants from every source mode. Register 2 produces absolute addressing and two more constants. Register 0, the program counter, turns indexed and post-increment modes into symbolic and immediate modes. The decoder sits between instruction fetch and operand fetch in a core pipeline. It accepts one field set per cycle and returns registered results one cycle later.

Top module: `opmode_decoder`

## Requirements
- R1: After a synchronous reset, out_valid is 0 and all result outputs are 0. A field set applied with in_valid=1 at a rising edge appears on the outputs, with out_valid=1, after that edge. out_valid is 0 in a cycle that follows one with in_valid=0.
- R2: Kinds are encoded as 0 none, 1 register, 2 indexed, 3 symbolic, 4 absolute, 5 indirect, 6 post-increment, 7 immediate and 8 constant. For source registers 1 and 4 to 15, source mode 00 gives register, 01 gives indexed with an extension word, 10 gives indirect and 11 gives post-increment.
- R3: Source register 3 always yields kind constant with no extension word. Modes 00, 01, 10 and 11 give the values 0x0000, 0x0001, 0x0002 and 0xFFFF.
- R4: Source register 2 gives register for mode 00 and absolute with an extension word for mode 01. It gives constant 0x0004 for mode 10 and constant 0x0008 for mode 11.
- R5: Source register 0 gives register for mode 00, symbolic with an extension word for mode 01, indirect for mode 10, and immediate with an extension word for mode 11.
- R6: For two-operand instructions, destination mode 0 gives register with no extension word. Destination mode 1 gives symbolic for register 0, absolute for register 2 and indexed for every other register, each with one extension word.
- R7: len_words equals 1 plus one for each side that takes an extension word, so it lies in the range 1 to 3.
- R8: cycles equals 1, plus 1 for an indirect, post-increment or immediate source, plus 2 for an indexed, symbolic or absolute source, plus 3 for an indexed, symbolic or absolute destination.
- R9: inc_step is 0 unless the source kind is post-increment. When it is, inc_step is 1 for a byte operation and 2 for a word operation, except that register 1 always steps by 2.
- R10: With single_op=1 the destination fields are ignored. dst_kind is 0 (none), dst_ext is 0, and the length and cycle count depend on the source alone.
- R11: const_val is 0 when the source is not a constant. The all-ones constant reads 0x00FF when byte_op=1, and the other constants do not depend on byte_op.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Field set present this cycle |
| single_op | input | 1 | Instruction has only one operand |
| byte_op | input | 1 | Byte-sized operation |
| src_reg | input | 4 | Source (or sole operand) register number |
| src_mode | input | 2 | Source addressing mode |
| dst_reg | input | 4 | Destination register number |
| dst_mode | input | 1 | Destination addressing mode |
| out_valid | output | 1 | Results valid |
| src_kind | output | 4 | Source operand kind |
| dst_kind | output | 4 | Destination operand kind |
| const_val | output | 16 | Generated constant value |
| src_ext | output | 1 | Source takes an extension word |
| dst_ext | output | 1 | Destination takes an extension word |
| inc_step | output | 2 | Post-increment step in bytes |
| len_words | output | 2 | Instruction length in words |
| cycles | output | 3 | Execution cycle count |

## Verification
The assertions assume that reset is held for at least one edge before the first valid field set. They also assume that every input is a known value whenever in_valid is high. The kind relations they check (constants without extension words, steps only on post-increment, cycles never below length) hold for any combination of fields. The stimulus drives only fully specified field sets, changing them half a cycle away from the sampling edge. It covers every combination of register, modes, size and format, so no encoding lies outside what the checks assume.

// File: rtl/opm_pkg.sv
package opm_pkg;
  typedef enum logic [3:0] {
    K_NONE     = 4'd0,
    K_REG      = 4'd1,
    K_INDEXED  = 4'd2,
    K_SYMBOLIC = 4'd3,
    K_ABSOLUTE = 4'd4,
    K_INDIRECT = 4'd5,
    K_AUTOINC  = 4'd6,
    K_IMMED    = 4'd7,
    K_CONST    = 4'd8
  } opnd_kind_e;

  localparam int REG_PC = 0;
  localparam int REG_SP = 1;
  localparam int REG_SR = 2;
  localparam int REG_CG = 3;

  localparam int MAX_LEN = 3;
  localparam int MAX_CYC = 6;
endpackage

// File: rtl/opm_src_decode.sv
module opm_src_decode
  import opm_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8,
  parameter int REG_W  = 4
) (
  input  logic [REG_W-1:0]  reg_sel,
  input  logic [1:0]        mode,
  input  logic              byte_op,
  output opnd_kind_e        kind,
  output logic              ext,
  output logic [DATA_W-1:0] cval,
  output logic [1:0]        step
);
  localparam logic [DATA_W-1:0] ALL_ONES  = '1;
  localparam logic [DATA_W-1:0] BYTE_ONES = {{(DATA_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};

  logic is_pc, is_sp, is_sr, is_cg;
  assign is_pc = (reg_sel == REG_W'(REG_PC));
  assign is_sp = (reg_sel == REG_W'(REG_SP));
  assign is_sr = (reg_sel == REG_W'(REG_SR));
  assign is_cg = (reg_sel == REG_W'(REG_CG));

  always_comb begin
    kind = K_REG;
    ext  = 1'b0;
    cval = '0;
    step = 2'd0;
    if (is_cg) begin
      kind = K_CONST;
      unique case (mode)
        2'b00: cval = '0;
        2'b01: cval = DATA_W'(1);
        2'b10: cval = DATA_W'(2);
        default: cval = byte_op ? BYTE_ONES : ALL_ONES;
      endcase
    end else begin
      unique case (mode)
        2'b00: kind = K_REG;
        2'b01: begin
          ext  = 1'b1;
          kind = is_pc ? K_SYMBOLIC : (is_sr ? K_ABSOLUTE : K_INDEXED);
        end
        2'b10: begin
          if (is_sr) begin
            kind = K_CONST;
            cval = DATA_W'(4);
          end else begin
            kind = K_INDIRECT;
          end
        end
        default: begin
          if (is_sr) begin
            kind = K_CONST;
            cval = DATA_W'(8);
          end else if (is_pc) begin
            kind = K_IMMED;
            ext  = 1'b1;
          end else begin
            kind = K_AUTOINC;
            step = (byte_op && !is_sp) ? 2'd1 : 2'd2;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/opm_dst_decode.sv
module opm_dst_decode
  import opm_pkg::*;
#(
  parameter int REG_W = 4
) (
  input  logic [REG_W-1:0] reg_sel,
  input  logic             mode,
  input  logic             absent,
  output opnd_kind_e       kind,
  output logic             ext
);
  always_comb begin
    kind = K_NONE;
    ext  = 1'b0;
    if (!absent) begin
      if (!mode) begin
        kind = K_REG;
      end else begin
        ext = 1'b1;
        if (reg_sel == REG_W'(REG_PC))      kind = K_SYMBOLIC;
        else if (reg_sel == REG_W'(REG_SR)) kind = K_ABSOLUTE;
        else                                kind = K_INDEXED;
      end
    end
  end
endmodule

// File: rtl/opm_cost.sv
module opm_cost
  import opm_pkg::*;
#(
  parameter int LEN_W = 2,
  parameter int CYC_W = 3
) (
  input  opnd_kind_e       src_kind,
  input  opnd_kind_e       dst_kind,
  input  logic             src_ext,
  input  logic             dst_ext,
  output logic [LEN_W-1:0] len_words,
  output logic [CYC_W-1:0] cycles
);
  logic [CYC_W-1:0] src_cost, dst_cost;

  always_comb begin
    unique case (src_kind)
      K_INDIRECT, K_AUTOINC, K_IMMED:    src_cost = CYC_W'(1);
      K_INDEXED, K_SYMBOLIC, K_ABSOLUTE: src_cost = CYC_W'(2);
      default:                           src_cost = '0;
    endcase
    unique case (dst_kind)
      K_INDEXED, K_SYMBOLIC, K_ABSOLUTE: dst_cost = CYC_W'(3);
      default:                           dst_cost = '0;
    endcase
  end

  assign len_words = LEN_W'(1) + LEN_W'(src_ext) + LEN_W'(dst_ext);
  assign cycles    = CYC_W'(1) + src_cost + dst_cost;
endmodule

// File: rtl/opmode_decoder.sv
module opmode_decoder
  import opm_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8,
  parameter int REG_W  = 4,
  localparam int LEN_W = $clog2(MAX_LEN + 1),
  localparam int CYC_W = $clog2(MAX_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              single_op,
  input  logic              byte_op,
  input  logic [REG_W-1:0]  src_reg,
  input  logic [1:0]        src_mode,
  input  logic [REG_W-1:0]  dst_reg,
  input  logic              dst_mode,
  output logic              out_valid,
  output logic [3:0]        src_kind,
  output logic [3:0]        dst_kind,
  output logic [DATA_W-1:0] const_val,
  output logic              src_ext,
  output logic              dst_ext,
  output logic [1:0]        inc_step,
  output logic [LEN_W-1:0]  len_words,
  output logic [CYC_W-1:0]  cycles
);
  opnd_kind_e        s_kind_c, d_kind_c;
  logic              s_ext_c, d_ext_c;
  logic [DATA_W-1:0] cval_c;
  logic [1:0]        step_c;
  logic [LEN_W-1:0]  len_c;
  logic [CYC_W-1:0]  cyc_c;

  opm_src_decode #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .REG_W(REG_W)) u_src (
    .reg_sel(src_reg), .mode(src_mode), .byte_op(byte_op),
    .kind(s_kind_c), .ext(s_ext_c), .cval(cval_c), .step(step_c)
  );

  opm_dst_decode #(.REG_W(REG_W)) u_dst (
    .reg_sel(dst_reg), .mode(dst_mode), .absent(single_op),
    .kind(d_kind_c), .ext(d_ext_c)
  );

  opm_cost #(.LEN_W(LEN_W), .CYC_W(CYC_W)) u_cost (
    .src_kind(s_kind_c), .dst_kind(d_kind_c),
    .src_ext(s_ext_c), .dst_ext(d_ext_c),
    .len_words(len_c), .cycles(cyc_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      src_kind  <= '0;
      dst_kind  <= '0;
      const_val <= '0;
      src_ext   <= 1'b0;
      dst_ext   <= 1'b0;
      inc_step  <= '0;
      len_words <= '0;
      cycles    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        src_kind  <= s_kind_c;
        dst_kind  <= d_kind_c;
        const_val <= cval_c;
        src_ext   <= s_ext_c;
        dst_ext   <= d_ext_c;
        inc_step  <= step_c;
        len_words <= len_c;
        cycles    <= cyc_c;
      end
    end
  end

  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid));

  // R3
  const_noext_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && src_kind == 4'(K_CONST)) |-> !src_ext);

  // R9
  step_kind_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && inc_step != 2'd0) |-> src_kind == 4'(K_AUTOINC));

  // R6
  dst_ext_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && (dst_kind == 4'(K_INDEXED) || dst_kind == 4'(K_SYMBOLIC) ||
                   dst_kind == 4'(K_ABSOLUTE))) |-> dst_ext);

  // R8
  cyc_len_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (CYC_W'(len_words) <= cycles));

  // R10
  nodst_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && dst_kind == 4'(K_NONE)) |-> (!dst_ext && cycles <= CYC_W'(3)));
endmodule

// File: tb/sim_opmode_decoder.sv
`timescale 1ns/1ps
module sim_opmode_decoder;
  typedef struct packed {
    logic [3:0]  sk;
    logic [3:0]  dk;
    logic [15:0] cv;
    logic        se;
    logic        de;
    logic [1:0]  st;
    logic [1:0]  ln;
    logic [2:0]  cy;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, single_op = 1'b0, byte_op = 1'b0, dst_mode = 1'b0;
  logic [3:0] src_reg = '0, dst_reg = '0;
  logic [1:0] src_mode = '0;
  logic out_valid, src_ext, dst_ext;
  logic [3:0] src_kind, dst_kind;
  logic [15:0] const_val;
  logic [1:0] inc_step, len_words;
  logic [2:0] cycles;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  exp_t q[$];
  string tq[$];

  always #2.5 clk = ~clk;

  opmode_decoder u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .single_op(single_op),
    .byte_op(byte_op), .src_reg(src_reg), .src_mode(src_mode),
    .dst_reg(dst_reg), .dst_mode(dst_mode), .out_valid(out_valid),
    .src_kind(src_kind), .dst_kind(dst_kind), .const_val(const_val),
    .src_ext(src_ext), .dst_ext(dst_ext), .inc_step(inc_step),
    .len_words(len_words), .cycles(cycles)
  );

  function automatic exp_t model(input logic [3:0] s, input logic [1:0] a,
                                 input logic [3:0] d, input logic ad,
                                 input logic bw, input logic sgl);
    exp_t e;
    e = '0;
    if (s == 4'd3) begin
      e.sk = 4'd8;
      case (a)
        2'd0: e.cv = 16'h0000;
        2'd1: e.cv = 16'h0001;
        2'd2: e.cv = 16'h0002;
        default: e.cv = bw ? 16'h00FF : 16'hFFFF;
      endcase
    end else if (s == 4'd2 && a == 2'd1) begin
      e.sk = 4'd4; e.se = 1'b1;
    end else if (s == 4'd2 && a[1]) begin
      e.sk = 4'd8; e.cv = (a == 2'd2) ? 16'h0004 : 16'h0008;
    end else if (s == 4'd0 && a == 2'd1) begin
      e.sk = 4'd3; e.se = 1'b1;
    end else if (s == 4'd0 && a == 2'd3) begin
      e.sk = 4'd7; e.se = 1'b1;
    end else begin
      case (a)
        2'd0: e.sk = 4'd1;
        2'd1: begin e.sk = 4'd2; e.se = 1'b1; end
        2'd2: e.sk = 4'd5;
        default: begin e.sk = 4'd6; e.st = (bw && s != 4'd1) ? 2'd1 : 2'd2; end
      endcase
    end
    if (sgl)      e.dk = 4'd0;
    else if (!ad) e.dk = 4'd1;
    else begin
      e.de = 1'b1;
      e.dk = (d == 4'd0) ? 4'd3 : ((d == 4'd2) ? 4'd4 : 4'd2);
    end
    e.ln = 2'd1 + 2'(e.se) + 2'(e.de);
    e.cy = 3'd1 + ((e.sk >= 4'd5 && e.sk <= 4'd7) ? 3'd1 :
                   (e.sk >= 4'd2 && e.sk <= 4'd4) ? 3'd2 : 3'd0) + (e.de ? 3'd3 : 3'd0);
    return e;
  endfunction

  task automatic drive(input logic [3:0] s, input logic [1:0] a, input logic [3:0] d,
                       input logic ad, input logic bw, input logic sgl,
                       input exp_t e, input string tag);
    @(negedge clk); #1;
    src_reg = s; src_mode = a; dst_reg = d; dst_mode = ad;
    byte_op = bw; single_op = sgl; in_valid = 1'b1;
    q.push_back(e); tq.push_back(tag);
  endtask

  task automatic drive_m(input logic [3:0] s, input logic [1:0] a, input logic [3:0] d,
                         input logic ad, input logic bw, input logic sgl, input string tag);
    drive(s, a, d, ad, bw, sgl, model(s, a, d, ad, bw, sgl), tag);
  endtask

  // instruction word: [11:8] src, [7] dst mode, [6] byte, [5:4] src mode, [3:0] dst
  task automatic drive_word(input logic [15:0] w, input logic [1:0] ln,
                            input logic [2:0] cy, input string tag);
    exp_t e;
    e = model(w[11:8], w[5:4], w[3:0], w[7], w[6], 1'b0);
    e.ln = ln; e.cy = cy;
    drive(w[11:8], w[5:4], w[3:0], w[7], w[6], 1'b0, e, tag);
  endtask

  task automatic idle();
    @(negedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && out_valid) begin
        if (q.size() == 0) begin
          check("R1", 64'(out_valid), 64'd0);
        end else begin
          exp_t e, a;
          string t;
          e = q.pop_front(); t = tq.pop_front();
          a = {src_kind, dst_kind, const_val, src_ext, dst_ext, inc_step, len_words, cycles};
          check(t, 64'(a), 64'(e));
        end
      end
    end
  end

  // watchdog
  initial begin
    #(5.0 * 190000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1", {43'd0, out_valid, src_kind, dst_kind, const_val}, 64'd0);
    #1 rst = 1'b0;
    repeat (2) @(negedge clk);
    check("R1", 64'(out_valid), 64'd0);

    // table of encodings with lengths and cycle counts (R7, R8)
    drive_word(16'h540A, 2'd1, 3'd1, "R7");
    drive_word(16'h541A, 2'd2, 3'd3, "R7");
    drive_word(16'h542A, 2'd1, 3'd2, "R8");
    drive_word(16'h543A, 2'd1, 3'd2, "R8");
    drive_word(16'h501A, 2'd2, 3'd3, "R5");
    drive_word(16'h521A, 2'd2, 3'd3, "R4");
    drive_word(16'h503A, 2'd2, 3'd2, "R5");
    drive_word(16'h531A, 2'd1, 3'd1, "R3");
    drive_word(16'h5586, 2'd2, 3'd4, "R6");
    drive_word(16'h5292, 2'd3, 3'd6, "R7");
    drive_word(16'h50B8, 2'd3, 3'd5, "R8");
    drive_word(16'h5392, 2'd2, 3'd4, "R6");
    idle();
    repeat (2) @(negedge clk);
    check("R1", 64'(out_valid), 64'd0);

    // directed corners
    drive_m(4'd3, 2'd3, 4'd4, 1'b0, 1'b1, 1'b0, "R11");
    drive_m(4'd3, 2'd3, 4'd4, 1'b0, 1'b0, 1'b0, "R11");
    drive_m(4'd2, 2'd3, 4'd4, 1'b0, 1'b1, 1'b0, "R11");
    drive_m(4'd1, 2'd3, 4'd4, 1'b0, 1'b1, 1'b0, "R9");
    drive_m(4'd7, 2'd3, 4'd4, 1'b0, 1'b1, 1'b0, "R9");
    drive_m(4'd7, 2'd3, 4'd4, 1'b0, 1'b0, 1'b0, "R9");
    drive_m(4'd9, 2'd1, 4'd0, 1'b1, 1'b0, 1'b1, "R10");
    drive_m(4'd3, 2'd1, 4'd3, 1'b1, 1'b0, 1'b0, "R6");

    // exhaustive sweep
    for (int sg = 0; sg < 2; sg++)
      for (int s = 0; s < 16; s++)
        for (int a = 0; a < 4; a++)
          for (int d = 0; d < 16; d++)
            for (int ad = 0; ad < 2; ad++)
              for (int bw = 0; bw < 2; bw++) begin
                string tag;
                if (sg == 1)      tag = "R10";
                else if (s == 3)  tag = "R3";
                else if (s == 2)  tag = "R4";
                else if (s == 0)  tag = "R5";
                else              tag = "R2";
                drive_m(4'(s), 2'(a), 4'(d), 1'(ad), 1'(bw), 1'(sg), tag);
              end
    idle();
    repeat (4) @(negedge clk);
    check("R1", 64'(q.size()), 64'd0);
    done = 1;
    summary();
    $finish;
  end
endmodule